// File: doc/BRIEF.md
# Parallel NOR Flash Bus Front End

This block sits behind the pins of an emulated asynchronous parallel NOR flash and turns the active-low chip enable, output enable and write enable strobes into clean, clock-synchronous events. The strobes pass through a two-flop synchronizer and then a glitch filter, so a pulse that is too short never starts or ends a bus cycle. From the filtered strobes the block decodes four bus states: read, write, output disabled and standby.

A bus read drives the data bus from a word returned by the downstream array, or from a signature code when identification mode is selected. A bus write captures its address when both chip enable and write enable are low, which is the later of their two falling edges. It captures its data when the first of the two strobes rises. The completed write is handed to the command logic as a one-cycle valid pulse. In byte mode the top data pin serves as the lowest address bit, and only the low byte lane is driven. An inactivity timer flags automatic standby. A read that is in progress keeps driving while the block is in automatic standby.

Top module: `nor_bus_frontend`

## Requirements
- R1: With filtered chip enable low, output enable low and write enable high, and with byte select high (word mode), `dq_oe` becomes all ones and `dq_out` equals `rd_data` for the word at `rd_addr` = {addr, 0}.
- R2: Whenever filtered output enable or filtered chip enable is high, `dq_oe` is zero. `standby` is high exactly when filtered chip enable is high.
- R3: A write begins when filtered chip enable and write enable are both low while output enable is high. The address is captured at that moment. The data on `dq_in` is captured when the first of chip enable or write enable rises. `wr_valid` then pulses high for exactly one cycle, with `wr_addr` and `wr_data` holding the captured values.
- R4: If output enable goes low at any time during a write, that write is dropped and no `wr_valid` pulse is produced.
- R5: A low pulse on a strobe that lasts fewer than GLITCH_CYC clock cycles is ignored. It starts no read and no write.
- R6: `auto_stby` rises after IDLE_CYC cycles with no change on the filtered strobes or on the full address. It falls within two cycles of any change. An active read keeps `dq_oe` set while `auto_stby` is high.
- R7: During a read with `id_mode` high, address bits [1:0] select the code on the low byte: 00 gives 0x20, and 01 gives 0xEE when TOP_BOOT=1 or 0xEF when TOP_BOOT=0. Any other value gives 0x00. The upper byte is zero.
- R8: In byte mode (`byte_n` low), `dq_in[15]` is the lowest address bit. A read drives `dq_oe` = 0x00FF. `dq_out[7:0]` carries the low byte of the word when that bit is 0 and the high byte when it is 1.
- R9: A byte-mode write reports `wr_addr` = {addr, dq_in[15]} and `wr_data` = {8'h00, dq_in[7:0]}. A word-mode write reports `wr_addr` = {addr, 0} and `wr_data` = `dq_in`.
- R10: After reset, `dq_oe` is zero, `wr_valid` is low, `auto_stby` is low and `standby` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| byte_n | input | 1 | Low selects byte mode, high selects word mode |
| addr | input | AW | Word address pins |
| dq_in | input | DW | Data pins, input side; bit DW-1 is the low address bit in byte mode |
| id_mode | input | 1 | Selects signature codes on reads |
| dq_out | output | DW | Data pins, output side |
| dq_oe | output | DW | Per-pin output enable |
| rd_addr | output | AW+1 | Byte address presented to the array |
| rd_data | input | DW | Array word for `rd_addr` |
| wr_valid | output | 1 | One-cycle pulse for a completed write |
| wr_addr | output | AW+1 | Captured write byte address |
| wr_data | output | DW | Captured write data |
| standby | output | 1 | Filtered chip enable is high |
| auto_stby | output | 1 | Bus has been inactive for IDLE_CYC cycles |

## Verification
The assertions check on every cycle the properties that hold from cycle to cycle:
- the data bus is released whenever it is disabled;
- the upper byte lane stays released in byte mode, and the upper byte is zero in identification mode;
- a write pulse lasts a single cycle, and a dropped write never produces one;
- the captured address holds still during a write;
- the filter changes its output only toward the synchronized level;
- any activity clears automatic standby.

The bench scenarios are the only way to show the other behaviours:
- the ordering rules, where the address follows the later falling edge and the data the earlier rising edge;
- the rejection of short strobe pulses;
- the signature values;
- byte-lane selection;
- the full write records, matched against a scoreboard.

// File: rtl/nor_fe_pkg.sv
package nor_fe_pkg;

    localparam int NSTROBE = 3;

    localparam logic [7:0] MFR_CODE     = 8'h20;
    localparam logic [7:0] DEV_CODE_TOP = 8'hEE;
    localparam logic [7:0] DEV_CODE_BOT = 8'hEF;

    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_ACTIVE = 2'd1,
        WR_DROP   = 2'd2
    } wr_state_e;

endpackage

// File: rtl/nfe_strobe_filter.sv
module nfe_strobe_filter #(
    parameter int GLITCH_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic filt_n
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          filt;
    } flt_t;

    flt_t d, q;

    always_comb begin
        d = q;
        d.sync = {q.sync[0], raw_n};
        if (q.sync[1] != q.filt) begin
            if (q.cnt == CW'(GLITCH_CYC - 1)) begin
                d.filt = q.sync[1];
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= 2'b11;
            q.cnt  <= '0;
            q.filt <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign filt_n = q.filt;

    // R5: the filtered level only ever moves to the synchronized level
    a_r5_filter_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (q.filt != $past(q.filt)) |-> ($past(q.sync[1]) == q.filt));

endmodule

// File: rtl/nfe_wr_capture.sv
module nfe_wr_capture
    import nor_fe_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_f,
    input  logic          oe_f,
    input  logic          we_f,
    input  logic          byte_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic          wr_valid,
    output logic [AW:0]   wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int BW = DW / 2;

    typedef struct packed {
        wr_state_e     st;
        logic          bmode;
        logic [AW:0]   adr;
        logic [DW-1:0] dat;
        logic          vld;
    } cap_t;

    cap_t d, q;
    logic in_write;

    always_comb begin
        in_write = !ce_f && !we_f;
        d = q;
        d.vld = 1'b0;
        case (q.st)
            WR_IDLE: begin
                if (in_write) begin
                    if (oe_f) begin
                        d.st    = WR_ACTIVE;
                        d.bmode = !byte_n;
                        d.adr   = byte_n ? {addr, 1'b0} : {addr, dq_in[DW-1]};
                    end else begin
                        d.st = WR_DROP;
                    end
                end
            end
            WR_ACTIVE: begin
                if (!oe_f) begin
                    d.st = WR_DROP;
                end else if (!in_write) begin
                    d.st  = WR_IDLE;
                    d.vld = 1'b1;
                    d.dat = q.bmode ? {{(DW-BW){1'b0}}, dq_in[BW-1:0]} : dq_in;
                end
            end
            WR_DROP: begin
                if (!in_write) d.st = WR_IDLE;
            end
            default: d.st = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= WR_IDLE;
            q.bmode <= 1'b0;
            q.adr   <= '0;
            q.dat   <= '0;
            q.vld   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign wr_valid = q.vld;
    assign wr_addr  = q.adr;
    assign wr_data  = q.dat;

    // R3: a completed write is reported for one cycle only
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |=> !q.vld);

    // R3: the captured address holds while the write is open
    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == WR_ACTIVE) |=> $stable(q.adr));

    // R4: a dropped write never reports
    a_r4_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == WR_DROP) |=> !q.vld);

endmodule

// File: rtl/nfe_idle_timer.sv
module nfe_idle_timer
    import nor_fe_pkg::*;
#(
    parameter int AW       = 18,
    parameter int IDLE_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSTROBE-1:0] strobes,
    input  logic [AW:0]        full_addr,
    output logic               auto_stby
);
    localparam int CW = $clog2(IDLE_CYC + 1);

    typedef struct packed {
        logic [NSTROBE-1:0] prev_s;
        logic [AW:0]        prev_a;
        logic [CW-1:0]      cnt;
        logic               stby;
    } idl_t;

    idl_t d, q;
    logic activity;

    always_comb begin
        activity = (strobes != q.prev_s) || (full_addr != q.prev_a);
        d = q;
        d.prev_s = strobes;
        d.prev_a = full_addr;
        if (activity) begin
            d.cnt  = '0;
            d.stby = 1'b0;
        end else if (q.cnt == CW'(IDLE_CYC - 1)) begin
            d.stby = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.prev_s <= '1;
            q.prev_a <= '0;
            q.cnt    <= '0;
            q.stby   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign auto_stby = q.stby;

    // R6: any bus activity wakes the block on the next cycle
    a_r6_wake_on_activity: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !q.stby);

endmodule

// File: rtl/nor_bus_frontend.sv
module nor_bus_frontend
    import nor_fe_pkg::*;
#(
    parameter int AW         = 18,
    parameter int DW         = 16,
    parameter int GLITCH_CYC = 3,
    parameter int IDLE_CYC   = 8,
    parameter bit TOP_BOOT   = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          byte_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    input  logic          id_mode,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] dq_oe,
    output logic [AW:0]   rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          wr_valid,
    output logic [AW:0]   wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          standby,
    output logic          auto_stby
);
    localparam int BW = DW / 2;
    localparam logic [7:0] DEV_CODE = TOP_BOOT ? DEV_CODE_TOP : DEV_CODE_BOT;

    logic [NSTROBE-1:0] raw_s, filt_s;
    logic ce_f, oe_f, we_f;
    logic [AW:0] full_addr;
    logic rd_active;
    logic [BW-1:0] id_code;

    assign raw_s = {ce_n, oe_n, we_n};

    for (genvar gi = 0; gi < NSTROBE; gi++) begin : g_filt
        nfe_strobe_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_n  (raw_s[gi]),
            .filt_n (filt_s[gi])
        );
    end

    assign ce_f = filt_s[2];
    assign oe_f = filt_s[1];
    assign we_f = filt_s[0];

    assign full_addr = byte_n ? {addr, 1'b0} : {addr, dq_in[DW-1]};
    assign rd_addr   = full_addr;
    assign standby   = ce_f;

    nfe_wr_capture #(.AW(AW), .DW(DW)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_f     (ce_f),
        .oe_f     (oe_f),
        .we_f     (we_f),
        .byte_n   (byte_n),
        .addr     (addr),
        .dq_in    (dq_in),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    nfe_idle_timer #(.AW(AW), .IDLE_CYC(IDLE_CYC)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobes   (filt_s),
        .full_addr (full_addr),
        .auto_stby (auto_stby)
    );

    typedef struct packed {
        logic [DW-1:0] dout;
        logic [DW-1:0] doe;
    } rd_t;

    rd_t d, q;

    always_comb begin
        rd_active = !ce_f && !oe_f && we_f;
        case (addr[1:0])
            2'b00:   id_code = BW'(MFR_CODE);
            2'b01:   id_code = BW'(DEV_CODE);
            default: id_code = '0;
        endcase
        d = q;
        d.dout = '0;
        d.doe  = '0;
        if (rd_active) begin
            if (id_mode) begin
                d.dout[BW-1:0] = id_code;
            end else if (byte_n) begin
                d.dout = rd_data;
            end else begin
                d.dout[BW-1:0] = full_addr[0] ? rd_data[DW-1:BW] : rd_data[BW-1:0];
            end
            d.doe = byte_n ? {DW{1'b1}} : {{(DW-BW){1'b0}}, {BW{1'b1}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.dout <= '0;
            q.doe  <= '0;
        end else begin
            q <= d;
        end
    end

    assign dq_out = q.dout;
    assign dq_oe  = q.doe;

    // R2: bus released when output or chip enable is inactive
    a_r2_release_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_f || ce_f) |=> (dq_oe == '0));

    // R8: upper lane stays released during byte-mode reads
    a_r8_upper_lane_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && !byte_n) |=> (dq_oe[DW-1:BW] == '0));

    // R7: signature reads carry a zero upper byte
    a_r7_id_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && id_mode) |=> (dq_out[DW-1:BW] == '0));

endmodule

// File: tb/nor_bus_frontend_test.sv
module nor_bus_frontend_test;
    localparam int AW = 18;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, byte_n = 1'b1, id_mode = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out, dq_oe, rd_data, wr_data;
    logic [AW:0]   rd_addr, wr_addr;
    logic wr_valid, standby, auto_stby;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int pushed = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [AW:0]   a;
        logic [DW-1:0] d;
    } wr_item_t;
    wr_item_t exp_q[$];

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] w);
        return {w[7:0] ^ 8'h5A, w[7:0] + 8'h11};
    endfunction

    assign rd_data = mem_word(rd_addr[AW:1]);

    nor_bus_frontend #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .byte_n(byte_n), .addr(addr), .dq_in(dq_in), .id_mode(id_mode),
        .dq_out(dq_out), .dq_oe(dq_oe), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .standby(standby), .auto_stby(auto_stby)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on each write pulse
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            pulses++;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3 unexpected write: actual %h/%h expected none", wr_addr, wr_data);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                if (wr_addr !== e.a || wr_data !== e.d) begin
                    errors++;
                    $display("FAIL R3/R9 write record: actual %h/%h expected %h/%h",
                             wr_addr, wr_data, e.a, e.d);
                end
            end
        end
    end

    task automatic push(input logic [AW:0] a, input logic [DW-1:0] d);
        wr_item_t e;
        e.a = a;
        e.d = d;
        exp_q.push_back(e);
        pushed++;
    endtask

    // chip enable first, write enable pulses, write enable rises first
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit bmode, input bit lsb);
        if (bmode) push({a, lsb}, {8'h00, d[7:0]});
        else       push({a, 1'b0}, d);
        byte_n = !bmode;
        addr   = a;
        dq_in  = bmode ? {lsb, d[14:0]} : d;
        oe_n   = 1'b1;
        ce_n   = 1'b0;
        cyc(8);
        we_n = 1'b0;
        cyc(10);
        we_n = 1'b1;
        cyc(8);
        ce_n = 1'b1;
        cyc(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0;
        bit bad;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R10 reset state
        chk("R10 dq_oe", 32'(dq_oe), 32'h0);
        chk("R10 wr_valid", 32'(wr_valid), 32'h0);
        chk("R10 auto_stby", 32'(auto_stby), 32'h0);
        chk("R10 standby", 32'(standby), 32'h1);

        // R1 word reads
        addr = 18'h00123; ce_n = 1'b0; oe_n = 1'b0;
        cyc(12);
        chk("R1 oe word", 32'(dq_oe), 32'hFFFF);
        chk("R1 data 0x123", 32'(dq_out), 32'(mem_word(18'h00123)));
        addr = 18'h3FFFF;
        cyc(6);
        chk("R1 data 0x3FFFF", 32'(dq_out), 32'(mem_word(18'h3FFFF)));

        // R2 output disable and standby
        oe_n = 1'b1;
        cyc(12);
        chk("R2 oe high releases", 32'(dq_oe), 32'h0);
        chk("R2 standby low while ce low", 32'(standby), 32'h0);
        oe_n = 1'b0; ce_n = 1'b1;
        cyc(12);
        chk("R2 ce high releases", 32'(dq_oe), 32'h0);
        chk("R2 standby", 32'(standby), 32'h1);
        oe_n = 1'b1;
        cyc(6);

        // R3 plain word write
        do_write(18'h01A2B, 16'hBEEF, 1'b0, 1'b0);

        // R3 write enable falls first, chip enable later; chip enable rises first
        addr = 18'h00555; dq_in = 16'h0000; we_n = 1'b0;
        cyc(8);
        addr = 18'h02AAA; ce_n = 1'b0;
        push({18'h02AAA, 1'b0}, 16'h1234);
        cyc(10);
        addr = 18'h00777; dq_in = 16'h1234;
        cyc(4);
        ce_n = 1'b1;
        cyc(10);
        dq_in = 16'hFFFF;
        cyc(4);
        we_n = 1'b1;
        cyc(10);
        chk("R3 pulses after two writes", 32'(pulses), 32'd2);

        // R4 output enable drops during a write
        p0 = pulses;
        addr = 18'h00100; ce_n = 1'b0;
        cyc(6);
        we_n = 1'b0;
        cyc(8);
        oe_n = 1'b0;
        cyc(8);
        we_n = 1'b1;
        cyc(8);
        oe_n = 1'b1; ce_n = 1'b1;
        cyc(10);
        chk("R4 dropped write no pulse", 32'(pulses), 32'(p0));

        // R5 short write-enable pulse
        p0 = pulses;
        ce_n = 1'b0;
        cyc(8);
        we_n = 1'b0;
        cyc(2);
        we_n = 1'b1;
        cyc(12);
        ce_n = 1'b1;
        cyc(10);
        chk("R5 glitch no write", 32'(pulses), 32'(p0));

        // R5 short chip-enable pulse with output enable low
        oe_n = 1'b0;
        cyc(6);
        bad = 1'b0;
        ce_n = 1'b0;
        cyc(2);
        ce_n = 1'b1;
        for (int i = 0; i < 14; i++) begin
            cyc(1);
            if (dq_oe !== 16'h0) bad = 1'b1;
        end
        chk("R5 glitch no read", 32'(bad), 32'h0);
        oe_n = 1'b1;
        cyc(6);

        // R6 automatic standby while reading
        addr = 18'h00042; ce_n = 1'b0; oe_n = 1'b0;
        cyc(30);
        chk("R6 auto standby set", 32'(auto_stby), 32'h1);
        chk("R6 read still drives", 32'(dq_oe), 32'hFFFF);
        addr = 18'h00043;
        cyc(3);
        chk("R6 auto standby cleared", 32'(auto_stby), 32'h0);

        // R7 signature reads
        id_mode = 1'b1; addr = 18'h00000;
        cyc(6);
        chk("R7 manufacturer", 32'(dq_out), 32'h0020);
        addr = 18'h00001;
        cyc(6);
        chk("R7 device", 32'(dq_out), 32'h00EE);
        addr = 18'h00002;
        cyc(6);
        chk("R7 other", 32'(dq_out), 32'h0000);
        id_mode = 1'b0;

        // R8 byte-mode reads
        byte_n = 1'b0; addr = 18'h00010; dq_in = 16'h0000;
        cyc(14);
        chk("R8 oe byte", 32'(dq_oe), 32'h00FF);
        chk("R8 low byte", 32'(dq_out), 32'({8'h00, mem_word(18'h00010)[7:0]}));
        dq_in = 16'h8000;
        cyc(6);
        chk("R8 high byte", 32'(dq_out), 32'({8'h00, mem_word(18'h00010)[15:8]}));
        oe_n = 1'b1; ce_n = 1'b1;
        cyc(10);

        // R9 byte-mode write
        do_write(18'h0ABCD, 16'hABCD, 1'b1, 1'b1);
        do_write(18'h00F0F, 16'h5566, 1'b1, 1'b0);
        byte_n = 1'b1;
        cyc(10);

        chk("R3 all writes seen", 32'(pulses), 32'(pushed));
        chk("R9 scoreboard empty", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule